// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesizer

This block is a direct digital synthesis core that produces a stream of 12-bit samples for a parallel DAC. A 10-bit phase register advances by a programmable step on every clock and wraps modulo 1024. The full phase word addresses one of four waveform shapes, each holding one complete cycle of 1024 samples: sine, square, triangle and sawtooth. The output frequency is therefore step × fclk / 1024. A step of 1 gives the finest resolution and a step of 512 gives fclk/2.

The step and the waveform choice are taken from the input pins only when the load strobe is high. A new step applies from the next accumulation onward, so the phase continues smoothly and never jumps. The sine shape is stored as a quarter wave that is computed while the design is elaborated. The full wave is rebuilt by mirroring the address and flipping the amplitude. Samples use offset-binary coding, with mid-scale at 2048.

Top module: `dds_synth`

## Requirements
- R1: While `rst` is high at a rising edge, the phase, the captured step and the captured selection are cleared: step 0, selection sine, and the pipeline also clears. After that edge `sample` reads 2048.
- R2: At each rising edge out of reset, the phase becomes (phase + captured step) mod 1024. Adding past 1023 wraps around and does not saturate.
- R3: `freqWord` and `waveSel` are captured only at an edge where `load` is high. While `load` is low, changes on these pins have no effect on `sample`.
- R4: A sample has a fixed two-cycle latency. The sample after edge c+2 equals the waveform of the phase and selection held after edge c. A step captured at edge c is first added at edge c+1.
- R5: Selection code 0 is sine. Let s = sin(2π(p+0.5)/1024). For s ≥ 0 the output is 2048 + round(2047·s). For s < 0 the output is 2047 − round(2047·|s|). The result is exact to within 1 LSB.
- R6: Selection code 1 is square. It gives 4095 for phase 0..511 and 0 for phase 512..1023.
- R7: Selection code 2 is triangle. It gives 8·p for p < 512 and 8·(1023 − p) for p ≥ 512.
- R8: Selection code 3 is sawtooth. It gives 4·p.
- R9: A step of 1 repeats the output every 1024 cycles. A step of 512 alternates between two phases 512 apart, which is the fclk/2 limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| freqWord | input | 10 | Phase step offered for capture |
| waveSel | input | 2 | Waveform code offered for capture (0 sine, 1 square, 2 triangle, 3 sawtooth) |
| load | input | 1 | Capture strobe for `freqWord` and `waveSel` |
| sample | output | 12 | Registered offset-binary sample |

## Verification
The hardest case to reach from the ports is the instant a newly captured step and shape meet the pipeline. The phase and the shape seen by the output must stay paired across the two-cycle delay, with no stale or early value in between. The bench reaches this case by loading a new step and shape in the middle of a running waveform many times over. It also does this once from a known phase of zero, where the exact samples in the following cycles are fixed by hand. Long runs with steps of 1000 and 333 drive the phase through the wrap point at many different offsets. A step of 0 freezes the phase, so a stretch of toggling pins without a load can be seen to leave the output unchanged.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
  localparam int PHASE_W  = 10;
  localparam int SAMPLE_W = 12;

  typedef enum logic [1:0] {
    WAVE_SINE     = 2'd0,
    WAVE_SQUARE   = 2'd1,
    WAVE_TRIANGLE = 2'd2,
    WAVE_SAW      = 2'd3
  } waveSel_e;

  // strobes from control to the phase datapath
  typedef struct packed {
    logic clear;
    logic take;
    logic advance;
  } ddsStrobes_t;
endpackage

// File: rtl/dds_ctrl.sv
`timescale 1ns/1ps
module dds_ctrl
  import dds_pkg::*;
(
  input  logic        rst,
  input  logic        load,
  output ddsStrobes_t strobes
);
  always_comb begin
    strobes.clear   = rst;
    strobes.take    = load & ~rst;
    strobes.advance = ~rst;
  end
endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic          clk,
  input  ddsStrobes_t   strobes,
  input  logic [PW-1:0] freqIn,
  input  waveSel_e      selIn,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] step,
  output waveSel_e      selNow
);
  // captured configuration; new step used from the following edge
  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      step   <= '0;
      selNow <= WAVE_SINE;
    end else if (strobes.take) begin
      step   <= freqIn;
      selNow <= selIn;
    end
  end

  // modulo-2^PW accumulation, natural wrap
  always_ff @(posedge clk) begin
    if (strobes.clear)
      phase <= '0;
    else if (strobes.advance)
      phase <= phase + step;
  end
endmodule

// File: rtl/dds_wave_lut.sv
`timescale 1ns/1ps
module dds_wave_lut
  import dds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int SW = SAMPLE_W
) (
  input  logic          clk,
  input  logic          clear,
  input  logic [PW-1:0] phase,
  input  waveSel_e      selNow,
  output logic [SW-1:0] sample,
  output waveSel_e      selLate
);
  localparam int QDEPTH = 1 << (PW - 2);
  localparam int QAW    = PW - 2;
  localparam int MAG_W  = SW - 1;
  localparam longint AMP = (64'sd1 <<< MAG_W) - 1;
  localparam int SAW_SH = SW - PW;
  localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);

  // quarter-wave magnitude: AMP*sin((2i+1)*pi/(4*QDEPTH)), Q30 Taylor series
  function automatic logic [MAG_W-1:0] quarterMag(input int idx);
    longint x, term, sum;
    x = (longint'(2 * idx + 1) * 64'sd3373259426) / longint'(4 * QDEPTH);
    sum  = x;
    term = x;
    for (int n = 1; n <= 6; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return MAG_W'((sum * AMP + (64'sd1 <<< 29)) >>> 30);
  endfunction

  logic [MAG_W-1:0] sineRom [QDEPTH];

  for (genvar i = 0; i < QDEPTH; i++) begin : g_rom
    localparam logic [MAG_W-1:0] ENTRY = quarterMag(i);
    assign sineRom[i] = ENTRY;
  end

  // stage 1: align phase with the selection of the same cycle
  logic [PW-1:0] phD;
  always_ff @(posedge clk) begin
    if (clear) begin
      phD     <= '0;
      selLate <= WAVE_SINE;
    end else begin
      phD     <= phase;
      selLate <= selNow;
    end
  end

  // shape decode
  logic [1:0]       quad;
  logic [QAW-1:0]   qAddr;
  logic [MAG_W-1:0] mag;
  logic [SW-1:0]    sineVal, squareVal, triVal, sawVal, nextSample;

  always_comb begin
    quad    = phD[PW-1:PW-2];
    qAddr   = quad[0] ? ~phD[QAW-1:0] : phD[QAW-1:0];
    mag     = sineRom[qAddr];
    sineVal = quad[1] ? {1'b0, ~mag} : {1'b1, mag};
    squareVal = phD[PW-1] ? '0 : '1;
    triVal  = {phD[PW-2:0] ^ {(PW-1){phD[PW-1]}}, {(SAW_SH+1){1'b0}}};
    sawVal  = {phD, {SAW_SH{1'b0}}};
    case (selLate)
      WAVE_SINE:     nextSample = sineVal;
      WAVE_SQUARE:   nextSample = squareVal;
      WAVE_TRIANGLE: nextSample = triVal;
      default:       nextSample = sawVal;
    endcase
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (clear) sample <= MID;
    else       sample <= nextSample;
  end
endmodule

// File: rtl/dds_synth.sv
`timescale 1ns/1ps
module dds_synth
  import dds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int SW = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] freqWord,
  input  logic [1:0]    waveSel,
  input  logic          load,
  output logic [SW-1:0] sample
);
  ddsStrobes_t   strobes;
  logic [PW-1:0] phaseWord;
  logic [PW-1:0] stepWord;
  waveSel_e      selNow;
  waveSel_e      selLate;

  dds_ctrl u_ctrl (
    .rst     (rst),
    .load    (load),
    .strobes (strobes)
  );

  dds_phase_acc #(.PW(PW)) u_acc (
    .clk     (clk),
    .strobes (strobes),
    .freqIn  (freqWord),
    .selIn   (waveSel_e'(waveSel)),
    .phase   (phaseWord),
    .step    (stepWord),
    .selNow  (selNow)
  );

  dds_wave_lut #(.PW(PW), .SW(SW)) u_lut (
    .clk     (clk),
    .clear   (strobes.clear),
    .phase   (phaseWord),
    .selNow  (selNow),
    .sample  (sample),
    .selLate (selLate)
  );
endmodule

// File: rtl/dds_synth_chk.sv
`timescale 1ns/1ps
module dds_synth_chk #(
  parameter int PW = 10,
  parameter int SW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic [SW-1:0] sample,
  input logic [PW-1:0] phaseWord,
  input logic [PW-1:0] stepWord,
  input logic [1:0]    selNow,
  input logic [1:0]    selLate
);
  localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);

  // R1: reset leaves the output at mid-scale
  p_reset_mid_r1: assert property (@(posedge clk)
    $past(rst) |-> sample == MID);

  // R2: phase advances by the captured step, wrapping
  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> phaseWord == PW'($past(phaseWord) + $past(stepWord)));

  // R3: configuration holds without a load strobe
  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load) |-> (stepWord == $past(stepWord) && selNow == $past(selNow)));

  // R6: square only produces the two rails
  p_square_rail_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && selLate == 2'd1) |-> (sample == '0 || sample == '1));

  // R7: triangle samples are multiples of eight
  p_tri_grid_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && selLate == 2'd2) |-> sample[2:0] == 3'd0);

  // R8: sawtooth samples are multiples of four
  p_saw_grid_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && selLate == 2'd3) |-> sample[1:0] == 2'd0);
endmodule

bind dds_synth dds_synth_chk #(.PW(PW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .sample    (sample),
  .phaseWord (phaseWord),
  .stepWord  (stepWord),
  .selNow    (selNow),
  .selLate   (selLate)
);

// File: tb/sim_dds_synth.sv
`timescale 1ns/1ps
module sim_dds_synth;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  freqWord = '0;
  logic [1:0]  waveSel = '0;
  logic        load = 1'b0;
  logic [11:0] sample;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int mPhase, mK, mSel, mPhD, mSelD, mSample, mTol;

  always #5 clk = ~clk;

  dds_synth u0 (
    .clk(clk), .rst(rst), .freqWord(freqWord),
    .waveSel(waveSel), .load(load), .sample(sample)
  );

  // expected shape values, from R5..R8
  function automatic int expWave(input int p, input int sel);
    real s;
    int  m;
    case (sel)
      0: begin
        s = $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
        if (s >= 0.0) begin
          m = $rtoi(2047.0 * s + 0.5);
          return 2048 + m;
        end else begin
          m = $rtoi(-2047.0 * s + 0.5);
          return 2047 - m;
        end
      end
      1: return (p < 512) ? 4095 : 0;
      2: return (p < 512) ? 8 * p : 8 * (1023 - p);
      default: return 4 * p;
    endcase
  endfunction

  function automatic string waveTag(input int sel);
    case (sel)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic string segTag(input int id);
    case (id)
      2: return "R2";
      9: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      fails++;
      $display("FAIL %s: sample=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one clock: model updates after the edge, compare at negedge
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      mPhase = 0; mK = 0; mSel = 0; mPhD = 0; mSelD = 0; mSample = 2048; mTol = 0;
    end else begin
      mSample = expWave(mPhD, mSelD);
      mTol    = (mSelD == 0) ? 1 : 0;
      mPhD    = mPhase;
      mSelD   = mSel;
      mPhase  = (mPhase + mK) % 1024;
      if (load) begin
        mK   = int'(freqWord);
        mSel = int'(waveSel);
      end
    end
    @(negedge clk);
    check($sformatf("%s/%s", tag, rst ? "R1" : waveTag(mSelD)), int'(sample), mSample, mTol);
  endtask

  // step, selection, cycles, segment tag id
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{1,    0, 1030, 9},
    '{512,  1, 40,   9},
    '{7,    2, 300,  4},
    '{1000, 3, 200,  2},
    '{3,    0, 400,  4},
    '{333,  1, 100,  2},
    '{64,   2, 120,  4},
    '{511,  3, 80,   9}
  };

  initial begin
    int held;
    @(negedge clk);
    rst = 1'b1;
    tick("R1");
    tick("R1");
    check("R1 reset mid-scale", int'(sample), 2048, 0);

    // R4: known pairing from phase zero, sawtooth with step 256
    @(negedge clk);
    rst = 1'b0; freqWord = 10'd256; waveSel = 2'd3; load = 1'b1;
    tick("R4");
    load = 1'b0;
    tick("R4");
    tick("R4");
    check("R4 first saw sample", int'(sample), 0, 0);
    tick("R4");
    check("R4 second saw sample", int'(sample), 1024, 0);
    tick("R4");
    check("R4 third saw sample", int'(sample), 2048, 0);

    // vector walk: R2, R4, R9 and all shapes
    for (int v = 0; v < NVEC; v++) begin
      freqWord = 10'(VEC[v][0]);
      waveSel  = 2'(VEC[v][1]);
      load     = 1'b1;
      tick(segTag(VEC[v][3]));
      load = 1'b0;
      for (int c = 1; c < VEC[v][2]; c++) tick(segTag(VEC[v][3]));
    end

    // R3: freeze with step 0, then toggle pins without load
    freqWord = 10'd0; waveSel = 2'd1; load = 1'b1;
    tick("R3");
    load = 1'b0;
    for (int c = 0; c < 4; c++) tick("R3");
    held = int'(sample);
    for (int c = 0; c < 20; c++) begin
      freqWord = 10'(c * 37 + 5);
      waveSel  = 2'(c);
      tick("R3");
      check("R3 no load no change", int'(sample), held, 0);
    end

    // R1: reset in the middle of a run
    freqWord = 10'd77; waveSel = 2'd0; load = 1'b1;
    tick("R4");
    load = 1'b0;
    for (int c = 0; c < 30; c++) tick("R4");
    rst = 1'b1;
    tick("R1");
    check("R1 mid-run reset", int'(sample), 2048, 0);
    tick("R1");
    rst = 1'b0;
    for (int c = 0; c < 10; c++) tick("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule